// File: doc/BRIEF.md
# Dual Timer Peripheral with Interrupt Masking

This block is a small memory-mapped timer with a 32-bit register bus. It holds two counters.

The first is a 56-bit countdown event timer. Software starts it in two writes:

1. It writes the low 32 bits of the start value to one register.
2. It writes the control word. That word carries the upper 24 bits, an enable flag, a periodic-mode flag and a commit flag.

The control write joins the two halves and starts the countdown. On expiry the timer sets a pending flag. It then either stops (one-shot) or reloads the full value and carries on (periodic).

The second counter is a 64-bit up-counter that never stops. Software reads it as two halves, low half first. Reading the low half freezes the high half into a shadow register, so the pair stays consistent across a carry. Both counters advance only on cycles where the `tick` strobe is high; `tick` is derived elsewhere from a fixed reference rate. The interrupt line is the pending flag gated by a mask bit. The mask has separate set and clear addresses, and the pending flag is cleared by writing a one.

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous reset every register, both counters, the shadow, the mask and the pending flag are zero. `irq` and `bus_rdata` are low.
- R2: Control (0x004) is written with bit 30 (commit) and bit 24 (enable) set. The event counter loads {control[23:0], word at 0x000} and starts. A start value N ≥ 2 expires on exactly the N-th tick after that write, and a value below 2 expires on the first tick. Expiry sets the pending flag, seen as bit 0 of a read at 0x034.
- R3: With bit 28 clear (one-shot), the event timer stops at expiry. No further expiry happens until the next control write.
- R4: With bit 28 set (periodic), expiry reloads {control[23:0], word at 0x000} and the timer expires again every N ticks.
- R5: A control write with bit 24 clear halts the event timer, and no expiry follows while it is halted.
- R6: Neither counter changes on a cycle where `tick` is low. A control write outranks a tick that falls in the same cycle, for the event counter only.
- R7: The free-running counter adds one per tick. A read at 0x024 returns its low 32 bits and captures its high 32 bits into a shadow. A read at 0x028 returns that shadow.
- R8: Writing bit 0 = 1 at 0x02C enables the interrupt, and writing bit 0 = 1 at 0x030 disables it. Bit 0 of a read at either address returns the mask. The mask resets to disabled.
- R9: Writing bit 0 = 1 at 0x034 clears the pending flag, and a write with bit 0 = 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: `irq` equals the pending flag AND the mask, and changes on the same clock edge as they do.
- R11: A read at 0x000 returns the last low word written. A read at 0x004 returns bits [23:0], 24 and 28 as last written, with every other bit zero. Unmapped addresses read as zero.
- R12: `bus_rdata` is registered. It changes only on the clock edge that ends a cycle with `bus_re` high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable strobe at the reference rate |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Event timer interrupt, pending AND mask |

## Verification
The assertions only require `tick`, `bus_we` and `bus_re` to be known after reset. They accept a read and a write in the same cycle, and they accept a commit value of zero or one.

The random stimulus keeps the start value small (2 to 33) and the upper field mostly zero, so that expiries occur often within the run. It mixes control words with random enable, periodic and commit bits, and it strobes `tick` at random, so that ticks land on control writes and on pending clears. Directed cases pin down the exact expiry tick, the periodic reload, halting, and an expiry that collides with a clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFS_LOAD_LO = 8'h00;
  localparam logic [7:0] OFS_CTRL    = 8'h04;
  localparam logic [7:0] OFS_FREE_LO = 8'h24;
  localparam logic [7:0] OFS_FREE_HI = 8'h28;
  localparam logic [7:0] OFS_MSET    = 8'h2C;
  localparam logic [7:0] OFS_MCLR    = 8'h30;
  localparam logic [7:0] OFS_PEND    = 8'h34;

  localparam int CB_ENABLE = 24;
  localparam int CB_PERIOD = 28;
  localparam int CB_COMMIT = 30;

  typedef struct packed {
    logic wr_lo;
    logic wr_ctrl;
    logic wr_mset;
    logic wr_mclr;
    logic wr_pend;
    logic rd_flo;
  } strobe_t;
endpackage

// File: rtl/tmr_event.sv
module tmr_event #(
  parameter int EVT_W  = 56,
  parameter int DATA_W = 32,
  localparam int HI_W  = EVT_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] lo_data,
  input  logic              wr_ctrl,
  input  logic [HI_W-1:0]   ctrl_hi,
  input  logic              ctrl_en,
  input  logic              ctrl_per,
  input  logic              ctrl_commit,
  output logic [DATA_W-1:0] load_lo,
  output logic [HI_W-1:0]   hi_q,
  output logic              en_q,
  output logic              per_q,
  output logic              expire
);
  logic [EVT_W-1:0] cnt_q;
  logic             run_q;

  always_comb
    expire = tick && run_q && !wr_ctrl && (cnt_q <= EVT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_lo <= '0;
      hi_q    <= '0;
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (wr_lo) load_lo <= lo_data;
      if (wr_ctrl) begin
        hi_q  <= ctrl_hi;
        en_q  <= ctrl_en;
        per_q <= ctrl_per;
        run_q <= ctrl_en;
        if (ctrl_commit) cnt_q <= {ctrl_hi, load_lo};
      end else if (expire) begin
        if (per_q) begin
          cnt_q <= {hi_q, load_lo};
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else if (tick && run_q) begin
        cnt_q <= cnt_q - EVT_W'(1);
      end
    end
  end

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && run_q && !wr_ctrl && !expire) |=> (cnt_q == $past(cnt_q) - EVT_W'(1))); // R2
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
    (expire && !per_q) |=> !run_q); // R3
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
    (expire && per_q) |=> (run_q && cnt_q == $past({hi_q, load_lo}))); // R4
  AST_STOP_CTRL: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !ctrl_en) |=> !run_q); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_ctrl) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  localparam int HI_W  = CNT_W - DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] cnt_q,
  output logic [HI_W-1:0]  shadow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (tick)  cnt_q    <= cnt_q + CNT_W'(1);
      if (rd_lo) shadow_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R6
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (shadow_q == $past(cnt_q[CNT_W-1:DATA_W]))); // R7
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic pend_clr,
  output logic mask_q,
  output logic pend_q,
  output logic irq_q
);
  logic mask_d, pend_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_set)      mask_d = 1'b1;
    else if (mask_clr) mask_d = 1'b0;
    pend_d = pend_q;
    if (expire)        pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= pend_d & mask_d;
    end
  end

  AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend_q); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (mask_q && pend_q)); // R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mask_q && pend_q) |-> irq_q); // R10
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mask_clr |=> !mask_q); // R8
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 56,
  parameter int FREE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import tmr_pkg::*;
  localparam int EHI_W = EVT_W - DATA_W;
  localparam int FHI_W = FREE_W - DATA_W;

  strobe_t            stb;
  logic [DATA_W-1:0]  load_lo;
  logic [EHI_W-1:0]   hi_q;
  logic               en_q, per_q, expire;
  logic [FREE_W-1:0]  free_cnt;
  logic [FHI_W-1:0]   shadow;
  logic               mask_q, pend_q;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_bits;

  assign unused_bits = ^{bus_wdata[31], bus_wdata[29], bus_wdata[27:25],
                         free_cnt[FREE_W-1:DATA_W]};

  always_comb begin
    stb.wr_lo   = bus_we && (bus_addr == ADDR_W'(OFS_LOAD_LO));
    stb.wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    stb.wr_mset = bus_we && (bus_addr == ADDR_W'(OFS_MSET)) && bus_wdata[0];
    stb.wr_mclr = bus_we && (bus_addr == ADDR_W'(OFS_MCLR)) && bus_wdata[0];
    stb.wr_pend = bus_we && (bus_addr == ADDR_W'(OFS_PEND)) && bus_wdata[0];
    stb.rd_flo  = bus_re && (bus_addr == ADDR_W'(OFS_FREE_LO));
  end

  tmr_event #(.EVT_W(EVT_W), .DATA_W(DATA_W)) u_event (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_lo       (stb.wr_lo),
    .lo_data     (bus_wdata),
    .wr_ctrl     (stb.wr_ctrl),
    .ctrl_hi     (bus_wdata[EHI_W-1:0]),
    .ctrl_en     (bus_wdata[CB_ENABLE]),
    .ctrl_per    (bus_wdata[CB_PERIOD]),
    .ctrl_commit (bus_wdata[CB_COMMIT]),
    .load_lo     (load_lo),
    .hi_q        (hi_q),
    .en_q        (en_q),
    .per_q       (per_q),
    .expire      (expire)
  );

  tmr_freerun #(.CNT_W(FREE_W), .DATA_W(DATA_W)) u_free (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rd_lo    (stb.rd_flo),
    .cnt_q    (free_cnt),
    .shadow_q (shadow)
  );

  tmr_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .mask_set (stb.wr_mset),
    .mask_clr (stb.wr_mclr),
    .pend_clr (stb.wr_pend),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .irq_q    (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_LOAD_LO): rd_mux = load_lo;
      ADDR_W'(OFS_CTRL): begin
        rd_mux[EHI_W-1:0] = hi_q;
        rd_mux[CB_ENABLE] = en_q;
        rd_mux[CB_PERIOD] = per_q;
      end
      ADDR_W'(OFS_FREE_LO): rd_mux = free_cnt[DATA_W-1:0];
      ADDR_W'(OFS_FREE_HI): rd_mux = shadow;
      ADDR_W'(OFS_MSET), ADDR_W'(OFS_MCLR): rd_mux[0] = mask_q;
      ADDR_W'(OFS_PEND): rd_mux[0] = pend_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_lo;
  logic [23:0] m_hi;
  logic        m_en, m_per, m_run, m_mask, m_pend, m_irq;
  logic [55:0] m_cnt;
  logic [63:0] m_free;
  logic [31:0] m_sh, m_rd;

  always #5 clk = ~clk;

  dual_tick_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h24, 8'h28: return "R7";
      8'h2C, 8'h30: return "R8";
      8'h34:        return "R9";
      8'h00, 8'h04: return "R11";
      default:      return "R12";
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(logic [23:0] hi, bit en, bit per, bit commit);
    return {1'b0, commit, 1'b0, per, 3'b000, en, hi};
  endfunction

  task automatic model_reset();
    m_lo = '0; m_hi = '0; m_en = 0; m_per = 0; m_run = 0; m_mask = 0;
    m_pend = 0; m_irq = 0; m_cnt = '0; m_free = '0; m_sh = '0; m_rd = '0;
  endtask

  // one clock cycle: called at a falling edge, returns at the next one
  task automatic cyc(logic [7:0] a, bit we, bit re, logic [31:0] wd, bit tk);
    logic [31:0] n_lo, n_sh, n_rd;
    logic [23:0] n_hi;
    logic        n_en, n_per, n_run, n_mask, n_pend, ctrl_wr, exp_e;
    logic [55:0] n_cnt;
    logic [63:0] n_free;
    bus_addr = a; bus_we = we; bus_re = re; bus_wdata = wd; tick = tk;
    n_lo = m_lo; n_hi = m_hi; n_en = m_en; n_per = m_per; n_run = m_run;
    n_mask = m_mask; n_pend = m_pend; n_cnt = m_cnt; n_free = m_free;
    n_sh = m_sh; n_rd = m_rd;
    ctrl_wr = we && (a == 8'h04);
    exp_e = tk && m_run && !ctrl_wr && (m_cnt <= 56'd1);
    if (re) begin
      case (a)
        8'h00: n_rd = m_lo;
        8'h04: n_rd = ctrl_word(m_hi, m_en, m_per, 1'b0);
        8'h24: begin n_rd = m_free[31:0]; n_sh = m_free[63:32]; end
        8'h28: n_rd = m_sh;
        8'h2C, 8'h30: n_rd = {31'd0, m_mask};
        8'h34: n_rd = {31'd0, m_pend};
        default: n_rd = '0;
      endcase
    end
    if (we && a == 8'h00) n_lo = wd;
    if (ctrl_wr) begin
      n_hi = wd[23:0]; n_en = wd[24]; n_per = wd[28]; n_run = wd[24];
      if (wd[30]) n_cnt = {wd[23:0], m_lo};
    end else if (exp_e) begin
      if (m_per) n_cnt = {m_hi, m_lo};
      else begin n_cnt = '0; n_run = 0; end
    end else if (tk && m_run) n_cnt = m_cnt - 56'd1;
    if (tk) n_free = m_free + 64'd1;
    if (we && a == 8'h2C && wd[0]) n_mask = 1;
    else if (we && a == 8'h30 && wd[0]) n_mask = 0;
    if (exp_e) n_pend = 1;
    else if (we && a == 8'h34 && wd[0]) n_pend = 0;
    @(posedge clk);
    @(negedge clk);
    m_lo = n_lo; m_hi = n_hi; m_en = n_en; m_per = n_per; m_run = n_run;
    m_mask = n_mask; m_pend = n_pend; m_cnt = n_cnt; m_free = n_free;
    m_sh = n_sh; m_rd = n_rd; m_irq = n_pend & n_mask;
    chk("R10 irq", {63'd0, irq}, {63'd0, m_irq});
    chk(re ? tag_of(a) : "R12 hold", {32'd0, bus_rdata}, {32'd0, m_rd});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(a, 1, 0, d, 0);
  endtask
  task automatic rd(logic [7:0] a);
    cyc(a, 0, 1, 32'd0, 0);
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(8'h10, 0, 0, 32'd0, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    model_reset();
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 rdata", {32'd0, bus_rdata}, 64'd0);
    rd(8'h00); rd(8'h04); rd(8'h24); rd(8'h28); rd(8'h2C); rd(8'h34);
    chk("R1 pend", {32'd0, bus_rdata}, 64'd0);
    rd(8'h3C);
    chk("R11 unmapped", {32'd0, bus_rdata}, 64'd0);

    // R8: mask set / clear
    wr(8'h2C, 32'd1); rd(8'h30);
    chk("R8 set", {32'd0, bus_rdata}, 64'd1);
    wr(8'h30, 32'd1); rd(8'h2C);
    chk("R8 clr", {32'd0, bus_rdata}, 64'd0);
    wr(8'h2C, 32'd1);

    // R2: one-shot of 5 ticks, exact expiry tick
    wr(8'h00, 32'd5);
    wr(8'h04, ctrl_word(24'd0, 1, 0, 1));
    rd(8'h04);
    chk("R11 ctrl", {32'd0, bus_rdata}, {32'd0, ctrl_word(24'd0, 1, 0, 0)});
    ticks(4); rd(8'h34);
    chk("R2 early", {32'd0, bus_rdata}, 64'd0);
    ticks(1); rd(8'h34);
    chk("R2 expire", {32'd0, bus_rdata}, 64'd1);
    chk("R10 raised", {63'd0, irq}, 64'd1);

    // R3: one-shot stays stopped
    wr(8'h34, 32'd1); ticks(20); rd(8'h34);
    chk("R3 stopped", {32'd0, bus_rdata}, 64'd0);

    // R4: periodic reload of 3
    wr(8'h00, 32'd3);
    wr(8'h04, ctrl_word(24'd0, 1, 1, 1));
    ticks(3); rd(8'h34);
    chk("R4 first", {32'd0, bus_rdata}, 64'd1);
    wr(8'h34, 32'd1); ticks(2); rd(8'h34);
    chk("R4 mid", {32'd0, bus_rdata}, 64'd0);
    ticks(1); rd(8'h34);
    chk("R4 second", {32'd0, bus_rdata}, 64'd1);

    // R5: halt by writing an enable of zero
    wr(8'h34, 32'd1);
    wr(8'h00, 32'd4);
    wr(8'h04, ctrl_word(24'd0, 1, 0, 1));
    ticks(2); wr(8'h04, 32'd0); ticks(10); rd(8'h34);
    chk("R5 halted", {32'd0, bus_rdata}, 64'd0);

    // R2: upper field takes part in the start value
    wr(8'h04, ctrl_word(24'd1, 1, 0, 1)); ticks(100); rd(8'h34);
    chk("R2 upper", {32'd0, bus_rdata}, 64'd0);

    // R6: no tick, no progress
    wr(8'h00, 32'd3);
    wr(8'h04, ctrl_word(24'd0, 1, 0, 1));
    for (int i = 0; i < 10; i++) cyc(8'h10, 0, 0, 32'd0, 0);
    rd(8'h34);
    chk("R6 idle", {32'd0, bus_rdata}, 64'd0);
    ticks(3); rd(8'h34);
    chk("R6 run", {32'd0, bus_rdata}, 64'd1);

    // R9: expiry beats a same-cycle clear; a zero write does nothing
    wr(8'h34, 32'd1);
    wr(8'h00, 32'd2);
    wr(8'h04, ctrl_word(24'd0, 1, 0, 1));
    ticks(1);
    cyc(8'h34, 1, 0, 32'd1, 1);
    rd(8'h34);
    chk("R9 collide", {32'd0, bus_rdata}, 64'd1);
    wr(8'h34, 32'd0); rd(8'h34);
    chk("R9 zero", {32'd0, bus_rdata}, 64'd1);
    wr(8'h34, 32'd1); rd(8'h34);
    chk("R9 clear", {32'd0, bus_rdata}, 64'd0);

    // R7: shadow holds across ticks
    rd(8'h24);
    chk("R7 low", {32'd0, bus_rdata}, {32'd0, m_free[31:0] - 32'd0});
    ticks(7); rd(8'h28);
    chk("R7 shadow", {32'd0, bus_rdata}, 64'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      logic [7:0] a;
      bit tk;
      op = $urandom % 16;
      tk = ($urandom % 3) != 0;
      case (op)
        0: cyc(8'h00, 1, 0, 32'd2 + ($urandom % 32), tk);
        1: cyc(8'h04, 1, 0, ctrl_word(($urandom % 8 == 0) ? 24'(1) : 24'd0,
                                      bit'($urandom % 4 != 0), bit'($urandom % 2),
                                      bit'($urandom % 4 != 0)), tk);
        2: cyc(8'h2C, 1, 0, $urandom, tk);
        3: cyc(8'h30, 1, 0, 32'($urandom % 2), tk);
        4: cyc(8'h34, 1, 0, $urandom, tk);
        5, 6, 7, 8: begin
          case ($urandom % 8)
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h24; 3: a = 8'h28;
            4: a = 8'h2C; 5: a = 8'h30; 6: a = 8'h34; default: a = 8'h18;
          endcase
          cyc(a, bit'($urandom % 8 == 0), 1, 32'd0, tk);
        end
        default: cyc(8'h10, 0, 0, 32'd0, tk);
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule